// File: doc/BRIEF.md
# Trimmed Seconds Divider

This block turns a stream of 32768 Hz oscillator strobes into a one-cycle seconds pulse. The strobe arrives as a one-cycle enable in the system clock domain. A host supplies a 5-bit signed trim code. Each trim step adds or removes exactly one oscillator strobe from the length of a second. One step equals about 30.5 ppm, and the range is ±10 steps, so up to about ±305 ppm of crystal error can be corrected.

The trim code uses sign-magnitude form. Bit 4 is the sign, and bits 3:0 are the magnitude. A clear sign bit makes the clock run faster, so the second is shorter. A set sign bit makes the second longer. The code is sampled only at a second boundary, so no second is ever counted with two different codes. The code in force is returned on a read-only output, after saturation and normalisation.

Control is a two-state machine:
- `ST_INIT` is entered on reset. In it the block latches the first trim code.
- It always moves on to `ST_COUNT` on the next clock.
- `ST_COUNT` stays in itself. It counts strobes, and on the strobe that ends the second it raises the pulse, restarts the count and latches the next code.
- Reset returns the machine to `ST_INIT` from any state.

Top module: `trim_sec_divider`

## Requirements
- R1: While reset is asserted, `sec_pulse` is low and `trim_applied` reads 0, even when strobes are present.
- R2: With a trim magnitude of 0, one pulse is issued for every `BASE_COUNT` (32768 by default) strobes.
- R3: With sign bit 4 = 0 and magnitude m, a second lasts `BASE_COUNT - m` strobes.
- R4: With sign bit 4 = 1 and magnitude m, a second lasts `BASE_COUNT + m` strobes.
- R5: A magnitude in bits 3:0 above 10 is treated as 10. `trim_applied` shows magnitude 10 with the sign that was given.
- R6: A magnitude of 0 with either sign gives no adjustment, and `trim_applied` reads 5'b00000.
- R7: The trim code is sampled in the first cycle after reset and on each strobe that ends a second. Changes at other times affect neither the current second's length nor `trim_applied`. `trim_applied` takes the new value in the cycle after the pulse.
- R8: `sec_pulse` is high for exactly one clock cycle, in the same cycle as the strobe that completes the second.
- R9: Clock cycles without a strobe do not advance the count, so a second's length in strobes is independent of gaps between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_en | input | 1 | One-cycle oscillator strobe |
| trim_code | input | 5 | Requested trim: bit 4 is the sign (1 = slower), bits 3:0 are the magnitude |
| sec_pulse | output | 1 | One-cycle seconds pulse |
| trim_applied | output | 5 | Trim code in force, after saturation and normalisation |

## Verification
A corrupted strobe counter or latched period shows up as a seconds pulse one or more strobes early or late. The bench therefore counts strobes between pulses and compares every second against the length predicted from the code presented at the previous boundary. A wrong latch of the code appears on `trim_applied` at once, and at the latest by the end of the second it governs. Junk codes are driven in mid-second to catch sampling away from the boundary. Gapped strobe patterns expose counting on idle cycles within one second.

// File: rtl/trim_sec_pkg.sv
package trim_sec_pkg;

    typedef enum logic {
        ST_INIT  = 1'b0,
        ST_COUNT = 1'b1
    } sec_state_t;

endpackage

// File: rtl/trim_sat_decode.sv
module trim_sat_decode #(
    parameter int MAG_W      = 4,
    parameter int MAX_MAG    = 10,
    parameter int BASE_COUNT = 32768,
    parameter int CNT_W      = 16
) (
    input  logic [MAG_W:0]   code_in,
    output logic [MAG_W:0]   code_sat,
    output logic [CNT_W-1:0] period
);

    logic [MAG_W-1:0] raw_mag;
    logic [MAG_W-1:0] sat_mag;
    logic             neg;

    always_comb begin
        raw_mag  = code_in[MAG_W-1:0];
        sat_mag  = (int'(raw_mag) > MAX_MAG) ? MAG_W'(MAX_MAG) : raw_mag;
        neg      = code_in[MAG_W] && (sat_mag != '0);
        code_sat = {neg, sat_mag};
        if (neg) begin
            period = CNT_W'(BASE_COUNT) + CNT_W'(sat_mag);
        end else begin
            period = CNT_W'(BASE_COUNT) - CNT_W'(sat_mag);
        end
    end

endmodule

// File: rtl/sec_tick_fsm.sv
module sec_tick_fsm
    import trim_sec_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_en,
    input  logic [CODE_W-1:0] next_code,
    input  logic [CNT_W-1:0]  next_period,
    output logic              sec_pulse,
    output logic [CODE_W-1:0] applied_code
);

    sec_state_t        state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  period_q;
    logic              at_end;

    assign at_end = (cnt == (period_q - 1'b1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_INIT;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_INIT:  state_nx = ST_COUNT;
            ST_COUNT: state_nx = ST_COUNT;
            default:  state_nx = ST_INIT;
        endcase
    end

    // counter and trim latch
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            period_q     <= '0;
            applied_code <= '0;
        end else begin
            unique case (state)
                ST_INIT: begin
                    cnt          <= '0;
                    period_q     <= next_period;
                    applied_code <= next_code;
                end
                ST_COUNT: begin
                    if (osc_en) begin
                        if (at_end) begin
                            cnt          <= '0;
                            period_q     <= next_period;
                            applied_code <= next_code;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sec_pulse = 1'b0;
        unique case (state)
            ST_INIT:  sec_pulse = 1'b0;
            ST_COUNT: sec_pulse = osc_en && at_end;
            default:  sec_pulse = 1'b0;
        endcase
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT) |-> (cnt < period_q)); // R3
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && !osc_en) |=> $stable(cnt)); // R9
    AST_READBACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && !sec_pulse) |=> $stable(applied_code)); // R7
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |=> !sec_pulse); // R8

endmodule

// File: rtl/trim_sec_divider.sv
module trim_sec_divider #(
    parameter int BASE_COUNT = 32768,
    parameter int MAX_MAG    = 10,
    parameter int MAG_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_en,
    input  logic [MAG_W:0]   trim_code,
    output logic             sec_pulse,
    output logic [MAG_W:0]   trim_applied
);

    localparam int CNT_W  = $clog2(BASE_COUNT + MAX_MAG + 1);
    localparam int CODE_W = MAG_W + 1;

    logic [CODE_W-1:0] code_sat;
    logic [CNT_W-1:0]  period;

    trim_sat_decode #(
        .MAG_W      (MAG_W),
        .MAX_MAG    (MAX_MAG),
        .BASE_COUNT (BASE_COUNT),
        .CNT_W      (CNT_W)
    ) u_decode (
        .code_in  (trim_code),
        .code_sat (code_sat),
        .period   (period)
    );

    sec_tick_fsm #(
        .CNT_W  (CNT_W),
        .CODE_W (CODE_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .osc_en       (osc_en),
        .next_code    (code_sat),
        .next_period  (period),
        .sec_pulse    (sec_pulse),
        .applied_code (trim_applied)
    );

    AST_MAG_SAT: assert property (@(posedge clk) disable iff (rst)
        int'(trim_applied[MAG_W-1:0]) <= MAX_MAG); // R5
    AST_ZERO_NORM: assert property (@(posedge clk) disable iff (rst)
        (trim_applied[MAG_W-1:0] == '0) |-> !trim_applied[MAG_W]); // R6
    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        sec_pulse |-> osc_en); // R8

endmodule

// File: tb/tb_trim_sec_divider.sv
`timescale 1ns/100ps
module tb_trim_sec_divider;

    localparam int BASE = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b0;
    logic [4:0] trim_code = 5'b0;
    logic       sec_pulse;
    logic [4:0] trim_applied;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    int         per_q[$];
    logic [4:0] rb_q[$];
    string      tag_q[$];

    trim_sec_divider #(.BASE_COUNT(BASE)) dut (
        .clk          (clk),
        .rst          (rst),
        .osc_en       (osc_en),
        .trim_code    (trim_code),
        .sec_pulse    (sec_pulse),
        .trim_applied (trim_applied)
    );

    always #2.5 clk = ~clk;

    function automatic int exp_mag(input logic [4:0] c);
        return (int'(c[3:0]) > 10) ? 10 : int'(c[3:0]);
    endfunction

    function automatic int exp_period(input logic [4:0] c);
        return c[4] ? BASE + exp_mag(c) : BASE - exp_mag(c);
    endfunction

    function automatic logic [4:0] exp_rb(input logic [4:0] c);
        int m;
        m = exp_mag(c);
        if (m == 0) return 5'b0;
        return {c[4], 4'(m)};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: one second of strobes under code cur; next code presented on the last strobe
    task automatic run_second(input logic [4:0] cur, input logic [4:0] nxt,
                              input int gap, input bit junk, input string tag);
        int p;
        p = exp_period(cur);
        per_q.push_back(p);
        rb_q.push_back(exp_rb(cur));
        tag_q.push_back(tag);
        for (int s = 0; s < p; s++) begin
            for (int g = 1; g < gap; g++) begin
                @(posedge clk); #1;
                osc_en = 1'b0;
            end
            @(posedge clk); #1;
            osc_en = 1'b1;
            if (junk && s == 2) trim_code = ~nxt;
            if (s == p - 1) trim_code = nxt;
        end
    endtask

    // monitor / scoreboard
    int  strobes = 0;
    int  spurious = 0;
    bit  prev_pulse = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (osc_en) strobes++;
                if (sec_pulse && (!osc_en || prev_pulse)) spurious++;
                if (sec_pulse) begin
                    if (per_q.size() == 0) begin
                        check("R2 unexpected pulse", 1, 0);
                    end else begin
                        int p;
                        logic [4:0] rb;
                        string t;
                        p  = per_q.pop_front();
                        rb = rb_q.pop_front();
                        t  = tag_q.pop_front();
                        check({t, " strobes per second"}, strobes, p);
                        check({t, " trim readback"}, int'(trim_applied), int'(rb));
                    end
                    strobes = 0;
                end
                prev_pulse = sec_pulse;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        trim_code = 5'b00000;
        osc_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pulse low in reset", int'(sec_pulse), 0);
        check("R1 readback zero in reset", int'(trim_applied), 0);
        @(posedge clk); #1;
        osc_en = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
        run_second(5'b00000, 5'b00011, 1, 1'b0, "R2");
        run_second(5'b00011, 5'b10100, 1, 1'b1, "R3 R7");
        run_second(5'b10100, 5'b01111, 2, 1'b0, "R4 R9");
        run_second(5'b01111, 5'b11101, 1, 1'b0, "R5 positive");
        run_second(5'b11101, 5'b10000, 1, 1'b1, "R5 negative R7");
        run_second(5'b10000, 5'b01010, 1, 1'b0, "R6");
        run_second(5'b01010, 5'b11010, 1, 1'b0, "R3 limit");
        run_second(5'b11010, 5'b00000, 3, 1'b0, "R4 limit R9");
        run_second(5'b00000, 5'b00000, 2, 1'b1, "R7 R2");
        @(posedge clk); #1;
        osc_en = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R2 all expected pulses seen", per_q.size(), 0);
        check("R8 pulses single-cycle and on strobes", spurious, 0);
        check("R9 no pulse while strobes stop", int'(sec_pulse), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule